// File: doc/BRIEF.md
# Bayer Virtual Pixel Fetch Sequencer

This block serves one request for a virtual pixel. A virtual pixel sits at the shared corner of four photocells on a random-access CMOS imager whose colour filter alternates green-red-green rows with blue-green-blue rows. Every 2x2 cell therefore holds two greens, one red and one blue. The block accepts a coordinate (x, y) over a ready/valid handshake and walks the imager's shared address bus through six fixed addresses. For each column access it waits for the imager's built-in A/D converter, then packs the four returned bytes into a single 32-bit word with a one-cycle valid strobe.

The bus order is: row y, column x, column x+1, row y+1, column x, column x+1. A qualifier output marks each bus cycle as a row or a column address. The converter latency is the parameter `CONV_CYC`, so the time per pixel can be tuned to the clock period in use. With `CONV_CYC` = K, one request takes 4K+7 cycles from acceptance to the result strobe. After the strobe the block spends one turnaround cycle before it takes the next request. At the right and top edges, the block repeats the last valid row or column instead of leaving the array.

Top module: `bayer_fetch_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is accepted in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` then stays low until the turnaround cycle after the result has passed. `img_addr_vld` is never high while `req_ready` is high.
- R2: After acceptance the bus carries exactly six addresses, in this order: row r0, column c0, column c1, row r1, column c0, column c1. `img_addr_col` is 0 for a row address and 1 for a column address. The first address appears in the cycle right after acceptance.
- R3: Each column address is followed by exactly `CONV_CYC` cycles with no address on the bus. The byte for that column is sampled from `img_data` in the last of those cycles and in no other cycle.
- R4: The result packs bytes as [7:0]=(r0,c0), [15:8]=(r0,c1), [23:16]=(r1,c0), [31:24]=(r1,c1).
- R5: `pix_valid` is high for a single cycle, exactly 4*`CONV_CYC`+7 cycles after the acceptance cycle.
- R6: In the cycle after `pix_valid`, `req_ready` and `img_addr_vld` are both low. `req_ready` returns high in the cycle after that.
- R7: r0 = min(y, ROWS-1) and c0 = min(x, COLS-1). r1 = r0+1 unless r0 = ROWS-1, in which case r1 = r0. c1 follows the same rule against COLS-1. No address at or beyond ROWS (for rows) or COLS (for columns) is ever driven.
- R8: `pix_word` changes only in a cycle where `pix_valid` is high, and it holds its value between results.
- R9: Changes on `req_x`, `req_y` and `req_valid` while a request is in progress have no effect on the addresses or on the result of that request.
- R10: An asynchronous active-low reset returns the block to idle at once: `req_ready` = 1, `img_addr_vld` = 0, `pix_valid` = 0 and `pix_word` = 0. This holds even in the middle of a walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_x | input | COL_W | Virtual pixel column |
| req_y | input | ROW_W | Virtual pixel row |
| img_addr | output | ADDR_W | Imager address bus (row or column) |
| img_addr_vld | output | 1 | An address is on the bus this cycle |
| img_addr_col | output | 1 | 1 = column address, 0 = row address |
| img_data | input | PIX_W | Converted photocell byte from the imager |
| pix_word | output | 4*PIX_W | Packed 2x2 colour group |
| pix_valid | output | 1 | Result strobe, one cycle |

## Verification
The assertions assume that the imager places each converted byte on `img_data` exactly `CONV_CYC` cycles after the matching column address. They also assume that reset is released away from the active clock edge. The stimulus meets both conditions. An imager model in the bench latches the row, delays each column access through a `CONV_CYC`-deep pipe, and drives a marker byte at every other time, so a sample taken in the wrong cycle shows up in the packed word. Reset is always changed at the falling edge. The coordinates cover the interior, both edges, and values past the array, so the clamping properties are exercised.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_WAIT,
    S_DONE,
    S_TURN
  } seq_state_t;

  localparam logic [2:0] LAST_STEP = 3'd5;

  // steps 0 and 3 are row-address steps
  function automatic logic step_is_row(input logic [2:0] step);
    return (step == 3'd0) || (step == 3'd3);
  endfunction

  // byte lane filled by a column step
  function automatic logic [1:0] step_lane(input logic [2:0] step);
    case (step)
      3'd1:    return 2'd0;
      3'd2:    return 2'd1;
      3'd4:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/bfs_axis_clamp.sv
module bfs_axis_clamp #(
  parameter int LIMIT = 640,
  parameter int IN_W  = 10,
  parameter int OUT_W = 10
) (
  input  logic [IN_W-1:0]  coord,
  output logic [OUT_W-1:0] lo,
  output logic [OUT_W-1:0] hi
);

  localparam logic [OUT_W-1:0] LAST = OUT_W'(LIMIT - 1);

  always_comb begin
    if (32'(coord) >= 32'(LIMIT - 1)) begin
      lo = LAST;
      hi = LAST;
    end else begin
      lo = OUT_W'(coord);
      hi = OUT_W'(coord) + 1'b1;
    end
  end

endmodule

// File: rtl/bfs_conv_timer.sv
module bfs_conv_timer #(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic en,
  output logic expired
);

  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] START = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (en && (cnt_q != '0));
    cnt_d  = load ? START : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/bfs_lane_pack.sv
module bfs_lane_pack #(
  parameter int LANES = 4,
  parameter int LW    = 8,
  localparam int SW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap,
  input  logic                fin,
  input  logic [SW-1:0]       sel,
  input  logic [LW-1:0]       din,
  output logic [LANES*LW-1:0] word
);

  logic [LANES*LW-1:0] lanes_q;
  logic [LANES*LW-1:0] lanes_d;
  logic [LANES*LW-1:0] word_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes_d[i*LW +: LW] = (cap && (sel == SW'(i))) ? din : lanes_q[i*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lanes_q <= '0;
    end else if (cap) begin
      lanes_q <= lanes_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (fin) begin
      word_q <= lanes_d;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/bayer_fetch_seq.sv
module bayer_fetch_seq #(
  parameter int COLS     = 640,
  parameter int ROWS     = 480,
  parameter int CONV_CYC = 3,
  parameter int PIX_W    = 8,
  localparam int COL_W   = $clog2(COLS),
  localparam int ROW_W   = $clog2(ROWS),
  localparam int ADDR_W  = (COL_W > ROW_W) ? COL_W : ROW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COL_W-1:0]   req_x,
  input  logic [ROW_W-1:0]   req_y,
  output logic [ADDR_W-1:0]  img_addr,
  output logic               img_addr_vld,
  output logic               img_addr_col,
  input  logic [PIX_W-1:0]   img_data,
  output logic [4*PIX_W-1:0] pix_word,
  output logic               pix_valid
);

  import bfs_pkg::*;

  seq_state_t state_q, state_d;
  logic [2:0] step_q, step_d;
  logic [COL_W-1:0] x_q;
  logic [ROW_W-1:0] y_q;
  logic accept, tmr_load, tmr_exp, cap, fin, row_step;
  logic [ADDR_W-1:0] r0, r1, c0, c1;
  logic [ADDR_W-1:0] addr_mux;

  // coordinate latch, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (accept) begin
      x_q <= req_x;
      y_q <= req_y;
    end
  end

  bfs_axis_clamp #(.LIMIT(ROWS), .IN_W(ROW_W), .OUT_W(ADDR_W)) u_row_clamp (
    .coord (y_q),
    .lo    (r0),
    .hi    (r1)
  );

  bfs_axis_clamp #(.LIMIT(COLS), .IN_W(COL_W), .OUT_W(ADDR_W)) u_col_clamp (
    .coord (x_q),
    .lo    (c0),
    .hi    (c1)
  );

  assign row_step = step_is_row(step_q);

  always_comb begin
    case (step_q)
      3'd0:         addr_mux = r0;
      3'd3:         addr_mux = r1;
      3'd1, 3'd4:   addr_mux = c0;
      default:      addr_mux = c1;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    accept   = 1'b0;
    tmr_load = 1'b0;
    cap      = 1'b0;
    fin      = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          step_d  = 3'd0;
          state_d = S_ADDR;
        end
      end
      S_ADDR: begin
        if (row_step) begin
          step_d = step_q + 3'd1;
        end else begin
          tmr_load = 1'b1;
          state_d  = S_WAIT;
        end
      end
      S_WAIT: begin
        if (tmr_exp) begin
          cap = 1'b1;
          if (step_q == LAST_STEP) begin
            fin     = 1'b1;
            state_d = S_DONE;
          end else begin
            step_d  = step_q + 3'd1;
            state_d = S_ADDR;
          end
        end
      end
      S_DONE:  state_d = S_TURN;
      S_TURN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  bfs_conv_timer #(.CYC(CONV_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .en      (state_q == S_WAIT),
    .expired (tmr_exp)
  );

  bfs_lane_pack #(.LANES(4), .LW(PIX_W)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap),
    .fin   (fin),
    .sel   (step_lane(step_q)),
    .din   (img_data),
    .word  (pix_word)
  );

  assign req_ready    = (state_q == S_IDLE);
  assign img_addr_vld = (state_q == S_ADDR);
  assign img_addr_col = (state_q == S_ADDR) && !row_step;
  assign img_addr     = (state_q == S_ADDR) ? addr_mux : '0;
  assign pix_valid    = (state_q == S_DONE);

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int COLS   = 640,
  parameter int ROWS   = 480,
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] img_addr,
  input logic              img_addr_vld,
  input logic              img_addr_col,
  input logic [WORD_W-1:0] pix_word,
  input logic              pix_valid
);

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_bus_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !img_addr_vld);

  assert_first_is_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (img_addr_vld && !img_addr_col));

  assert_col_then_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (img_addr_vld && img_addr_col) |=> !img_addr_vld);

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (!req_ready && !img_addr_vld));

  assert_addr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    img_addr_vld |-> (img_addr_col ? (32'(img_addr) < 32'(COLS))
                                   : (32'(img_addr) < 32'(ROWS))));

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pix_word) |-> pix_valid);

endmodule

bind bayer_fetch_seq bfs_checker #(
  .COLS   (COLS),
  .ROWS   (ROWS),
  .ADDR_W (ADDR_W),
  .WORD_W (4*PIX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .img_addr     (img_addr),
  .img_addr_vld (img_addr_vld),
  .img_addr_col (img_addr_col),
  .pix_word     (pix_word),
  .pix_valid    (pix_valid)
);

// File: tb/sim_bayer_fetch_seq.sv
module sim_bayer_fetch_seq;

  localparam int CLK_NS = 30;
  localparam int COLS = 640;
  localparam int ROWS = 480;
  localparam int K = 3;
  localparam int XW = 10;
  localparam int YW = 9;
  localparam int AW = 10;
  localparam int LAT = 4 * K + 7;
  localparam int NVEC = 8;
  // {x, y}
  localparam logic [XW+YW-1:0] VEC [NVEC] = '{
    {10'd0,    9'd0},
    {10'd5,    9'd7},
    {10'd100,  9'd200},
    {10'd638,  9'd478},
    {10'd639,  9'd479},
    {10'd639,  9'd3},
    {10'd4,    9'd479},
    {10'd1023, 9'd511}
  };

  logic clk, rst_n, req_valid, req_ready, img_addr_vld, img_addr_col, pix_valid;
  logic [XW-1:0] req_x;
  logic [YW-1:0] req_y;
  logic [AW-1:0] img_addr;
  logic [7:0] img_data;
  logic [31:0] pix_word;

  int total = 0;
  int bad = 0;

  bayer_fetch_seq #(.COLS(COLS), .ROWS(ROWS), .CONV_CYC(K), .PIX_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .img_addr(img_addr), .img_addr_vld(img_addr_vld),
    .img_addr_col(img_addr_col), .img_data(img_data), .pix_word(pix_word),
    .pix_valid(pix_valid)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [7:0] pix(input int r, input int c);
    return 8'((r * 5 + c * 3 + 1) & 255);
  endfunction

  // imager model: row latch plus K-deep conversion pipe
  logic [AW-1:0] row_l;
  logic [K-1:0] pv;
  logic [7:0] pd [K];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_l <= '0;
      pv <= '0;
    end else begin
      if (img_addr_vld && !img_addr_col) row_l <= img_addr;
      pv[0] <= img_addr_vld && img_addr_col;
      pd[0] <= pix(int'(row_l), int'(img_addr));
      for (int i = 1; i < K; i++) begin
        pv[i] <= pv[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end
  assign img_data = pv[K-1] ? pd[K-1] : 8'hEE;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  // results of the last request
  int got_lat, got_n;
  logic [AW-1:0] got_addr [8];
  logic got_col [8];
  logic [31:0] got_word;
  bit busy_ready, turn_ready, turn_bus, idle_ready;

  task automatic run_req(input logic [XW-1:0] x, input logic [YW-1:0] y, input bit hold);
    int n;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_x = x;
    req_y = y;
    n = 0;
    got_n = 0;
    busy_ready = 1'b0;
    forever begin
      @(negedge clk);
      n++;
      if (hold) begin
        req_x = 10'd300;
        req_y = 9'd300;
      end else begin
        req_valid = 1'b0;
      end
      if (img_addr_vld && got_n < 8) begin
        got_addr[got_n] = img_addr;
        got_col[got_n] = img_addr_col;
        got_n++;
      end
      if (req_ready) busy_ready = 1'b1;
      if (pix_valid || n > 200) break;
    end
    got_lat = n;
    got_word = pix_word;
    @(negedge clk);
    turn_ready = req_ready;
    turn_bus = img_addr_vld;
    req_valid = 1'b0;
    @(negedge clk);
    idle_ready = req_ready;
  endtask

  task automatic check_vec(input logic [XW-1:0] x, input logic [YW-1:0] y, input bit hold);
    int r0, r1, c0, c1;
    logic [AW-1:0] ea [6];
    logic ec [6];
    bit seq_ok;
    logic [31:0] ew;
    run_req(x, y, hold);
    r0 = (int'(y) >= ROWS - 1) ? ROWS - 1 : int'(y);
    r1 = (r0 == ROWS - 1) ? r0 : r0 + 1;
    c0 = (int'(x) >= COLS - 1) ? COLS - 1 : int'(x);
    c1 = (c0 == COLS - 1) ? c0 : c0 + 1;
    ea = '{AW'(r0), AW'(c0), AW'(c1), AW'(r1), AW'(c0), AW'(c1)};
    ec = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    seq_ok = (got_n == 6);
    for (int i = 0; i < 6; i++)
      if (i < got_n && (got_addr[i] !== ea[i] || got_col[i] !== ec[i])) seq_ok = 1'b0;
    check(seq_ok, "R2/R7", "address walk", 32'(got_n), 32'd6);
    ew = {pix(r1, c1), pix(r1, c0), pix(r0, c1), pix(r0, c0)};
    check(got_word === ew, "R4/R3", "packed word", got_word, ew);
    check(got_lat == LAT, "R5", "latency", 32'(got_lat), 32'(LAT));
    check(!busy_ready, "R1", "ready low while busy", 32'(busy_ready), 32'd0);
    check(!turn_ready && !turn_bus, "R6", "turnaround idle",
          {30'd0, turn_ready, turn_bus}, 32'd0);
    check(idle_ready, "R6", "ready after turnaround", 32'(idle_ready), 32'd1);
  endtask

  initial begin
    logic [31:0] held;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_x = '0;
    req_y = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready && !img_addr_vld && !pix_valid && pix_word == 32'd0, "R10",
          "reset state", {req_ready, img_addr_vld, pix_valid, pix_word[28:0]}, 32'h80000000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      check_vec(VEC[v][XW+YW-1:YW], VEC[v][YW-1:0], 1'b0);

    // R9: inputs changing mid-request ignored
    check_vec(10'd10, 9'd20, 1'b1);

    // R8: word holds while idle
    held = pix_word;
    repeat (6) @(negedge clk);
    check(pix_word === held, "R8", "word hold", pix_word, held);

    // R10: reset in the middle of a walk
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_x = 10'd50;
    req_y = 9'd60;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(req_ready && !img_addr_vld && !pix_valid && pix_word == 32'd0, "R10",
          "mid-walk reset", {req_ready, img_addr_vld, pix_valid, pix_word[28:0]}, 32'h80000000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: top-right corner again after reset
    check_vec(10'd700, 9'd479, 1'b0);

    finish_run();
  end

endmodule